// File: doc/BRIEF.md
# Banked Dual Address Pointer

This block keeps two 16-bit address pointers for an 8-bit microcontroller core and shows the CPU only one of them at a time. A single select flag, held in bit 0 of a small control register, decides which pointer is live. Both pointers sit behind the same two special-function byte addresses. Loads, byte writes, increments and the external-memory address output all act on the live pointer only. The other pointer stays untouched until the flag changes.

Software uses the pair for block transfers. One pointer walks the source and the other walks the destination. The code switches between them with a single increment of the control register, which flips the flag instead of setting it to a fixed value. The address output is combinational from the live pointer, so the access right after a switch already uses the newly selected pointer.

Top module: `ptr_pair_top`

## Requirements
- R1: After reset, both pointers hold 0000h and the select flag is 0. The address output reads 0000h, and the control register and both pointer bytes read 00h.
- R2: A write to SFR address 82h sets the low byte of the selected pointer, and a write to 83h sets its high byte. Reads of these addresses return the selected pointer's low and high bytes.
- R3: The control register sits at SFR address A2h, and bit 0 is the select flag (0 selects pointer 0, 1 selects pointer 1). A write sets the flag from write-data bit 0. The other seven bits always read 0, and writes to them are ignored.
- R4: A control-increment strobe toggles the select flag. Two strobes in a row return the flag to its starting value.
- R5: A 16-bit load writes only the selected pointer, and the unselected pointer keeps its value.
- R6: A pointer-increment strobe adds one to the selected pointer only. A carry out of the low byte propagates into the high byte, and FFFFh wraps to 0000h.
- R7: In any one cycle, a 16-bit load beats an SFR byte write, and either kind of write beats a pointer increment. The pointer ends up holding exactly the written value.
- R8: The address output equals the selected pointer, combinationally. Right after a select toggle it shows the other pointer with no extra cycle.
- R9: A write to the control register in the same cycle as a control-increment strobe wins, so the flag takes the written bit.
- R10: SFR reads of any address outside 82h, 83h and A2h return 00h. Writes to such addresses change neither pointer nor the select flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | SFR byte address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write enable |
| sfr_rdata | output | 8 | SFR read data for sfr_addr (combinational) |
| ctl_inc | input | 1 | Increment strobe for the control register (toggles select) |
| ld_en | input | 1 | 16-bit load strobe for the selected pointer |
| ld_val | input | 16 | Value for the 16-bit load |
| ptr_inc | input | 1 | Increment strobe for the selected pointer |
| xaddr | output | 16 | External-memory address from the selected pointer |

## Verification
The assertions assume that each strobe lasts one clock and that the select flag sampled at an edge is the one that routes that edge's load, byte write or increment. They also assume that the write data is stable while a write is enabled. The bench drives every input a fixed delay after the rising edge and drops the strobes after one cycle. Strobes are raised together only in the scenarios that test priority.

// File: rtl/ptr_pair_pkg.sv
package ptr_pair_pkg;
   // Which register an SFR address decodes to.
   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_LO   = 2'd1,
      HIT_HI   = 2'd2,
      HIT_CTL  = 2'd3
   } sfr_hit_e;
endpackage

// File: rtl/ptr_pair_decode.sv
module ptr_pair_decode
   import ptr_pair_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] LO_ADDR  = 'h82,
   parameter logic [ADDR_W-1:0] HI_ADDR  = 'h83,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 'hA2
) (
   input  logic [ADDR_W-1:0] addr,
   output sfr_hit_e          hit
);
   initial begin
      if (LO_ADDR == HI_ADDR || LO_ADDR == CTL_ADDR || HI_ADDR == CTL_ADDR)
         $error("ptr_pair_decode: SFR addresses must be distinct");
   end

   always_comb begin
      if (addr == LO_ADDR)       hit = HIT_LO;
      else if (addr == HI_ADDR)  hit = HIT_HI;
      else if (addr == CTL_ADDR) hit = HIT_CTL;
      else                       hit = HIT_NONE;
   end
endmodule

// File: rtl/ptr_pair_sel.sv
module ptr_pair_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_we,
   input  logic wbit,
   input  logic ctl_inc,
   output logic sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel <= 1'b0;
      else if (ctl_we)  sel <= wbit;
      else if (ctl_inc) sel <= ~sel;
   end

   // R4: an increment without a write flips the flag
   p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_inc && !ctl_we) |=> (sel != $past(sel)));

   // R9: a write wins over a simultaneous increment
   p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (sel == $past(wbit)));

   // R3: without write or increment the flag holds
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !ctl_inc) |=> $stable(sel));
endmodule

// File: rtl/ptr_pair_reg.sv
module ptr_pair_reg #(
   parameter int BYTE_W      = 8,
   parameter bit SPLIT_CARRY = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld,
   input  logic [2*BYTE_W-1:0]   ld_val,
   input  logic                  wr_lo,
   input  logic                  wr_hi,
   input  logic [BYTE_W-1:0]     wbyte,
   input  logic                  inc,
   output logic [2*BYTE_W-1:0]   q
);
   localparam int PTR_W = 2 * BYTE_W;

   logic [PTR_W-1:0] q_plus;

   generate
      if (SPLIT_CARRY) begin : g_split
         // Byte-wise adder: low byte carry ripples into the high byte
         logic [BYTE_W:0]   lo_sum;
         logic [BYTE_W-1:0] hi_sum;
         always_comb begin
            lo_sum = {1'b0, q[BYTE_W-1:0]} + {{BYTE_W{1'b0}}, 1'b1};
            hi_sum = q[PTR_W-1:BYTE_W] + {{(BYTE_W-1){1'b0}}, lo_sum[BYTE_W]};
            q_plus = {hi_sum, lo_sum[BYTE_W-1:0]};
         end
      end else begin : g_flat
         always_comb q_plus = q + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (ld)    q <= ld_val;
      else if (wr_lo) q[BYTE_W-1:0] <= wbyte;
      else if (wr_hi) q[PTR_W-1:BYTE_W] <= wbyte;
      else if (inc)   q <= q_plus;
   end

   // R6: a lone increment adds exactly one, modulo 2^PTR_W
   p_inc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && !wr_lo && !wr_hi) |=> (q == $past(q) + PTR_W'(1)));

   // R7: a load overrides everything else in its cycle
   p_ld_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (q == $past(ld_val)));

   // R2: a low-byte write leaves the high byte alone
   p_lo_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !ld) |=> (q[PTR_W-1:BYTE_W] == $past(q[PTR_W-1:BYTE_W])));

   // R5: with no request the pointer holds
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !wr_lo && !wr_hi && !inc) |=> $stable(q));
endmodule

// File: rtl/ptr_pair_top.sv
module ptr_pair_top
   import ptr_pair_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] LO_ADDR  = 'h82,
   parameter logic [ADDR_W-1:0] HI_ADDR  = 'h83,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 'hA2,
   parameter int SEL_BIT     = 0,
   parameter bit SPLIT_CARRY = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     sfr_addr,
   input  logic [BYTE_W-1:0]     sfr_wdata,
   input  logic                  sfr_we,
   output logic [BYTE_W-1:0]     sfr_rdata,
   input  logic                  ctl_inc,
   input  logic                  ld_en,
   input  logic [2*BYTE_W-1:0]   ld_val,
   input  logic                  ptr_inc,
   output logic [2*BYTE_W-1:0]   xaddr
);
   localparam int PTR_W   = 2 * BYTE_W;
   localparam int NUM_PTR = 2;

   initial begin
      if (BYTE_W < 2)
         $error("ptr_pair_top: BYTE_W must be at least 2");
      if (SEL_BIT < 0 || SEL_BIT >= BYTE_W)
         $error("ptr_pair_top: SEL_BIT outside control register");
   end

   sfr_hit_e hit;
   logic     sel_q;
   logic     ctl_we, lo_we, hi_we;
   logic [PTR_W-1:0]   ptr_q  [NUM_PTR];
   logic [NUM_PTR-1:0] ld_vec;

   ptr_pair_decode #(
      .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .CTL_ADDR(CTL_ADDR)
   ) u_dec (
      .addr(sfr_addr),
      .hit (hit)
   );

   always_comb begin
      ctl_we = sfr_we && (hit == HIT_CTL);
      lo_we  = sfr_we && (hit == HIT_LO);
      hi_we  = sfr_we && (hit == HIT_HI);
   end

   ptr_pair_sel u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_we (ctl_we),
      .wbit   (sfr_wdata[SEL_BIT]),
      .ctl_inc(ctl_inc),
      .sel    (sel_q)
   );

   for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
      localparam logic MINE = 1'(g);
      logic act;
      always_comb act = (sel_q == MINE);
      always_comb ld_vec[g] = act && ld_en;

      ptr_pair_reg #(.BYTE_W(BYTE_W), .SPLIT_CARRY(SPLIT_CARRY)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (act && ld_en),
         .ld_val(ld_val),
         .wr_lo (act && lo_we),
         .wr_hi (act && hi_we),
         .wbyte (sfr_wdata),
         .inc   (act && ptr_inc),
         .q     (ptr_q[g])
      );

      // R5: the unselected pointer is never disturbed
      p_unsel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_q != MINE) |=> (ptr_q[g] == $past(ptr_q[g])));
   end

   always_comb xaddr = sel_q ? ptr_q[1] : ptr_q[0];

   always_comb begin
      sfr_rdata = '0;
      unique case (hit)
         HIT_LO:   sfr_rdata = xaddr[BYTE_W-1:0];
         HIT_HI:   sfr_rdata = xaddr[PTR_W-1:BYTE_W];
         HIT_CTL:  sfr_rdata[SEL_BIT] = sel_q;
         default:  sfr_rdata = '0;
      endcase
   end

   // R5: at most one pointer receives a load in any cycle
   p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_vec));

   // R8: a toggle shows the other pointer on the next cycle
   p_switch_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_inc && !ctl_we) |=> (xaddr == (sel_q ? ptr_q[1] : ptr_q[0])) && (sel_q != $past(sel_q)));

   // R3: control reads expose only the select flag
   p_ctl_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_CTL) |-> ($countones(sfr_rdata) <= 1));
endmodule

// File: tb/ptr_pair_top_test.sv
`timescale 1ns/1ps
module ptr_pair_top_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  sfr_addr;
   logic [7:0]  sfr_wdata;
   logic        sfr_we;
   logic [7:0]  sfr_rdata;
   logic        ctl_inc;
   logic        ld_en;
   logic [15:0] ld_val;
   logic        ptr_inc;
   logic [15:0] xaddr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   ptr_pair_top uut (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
      .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ctl_inc(ctl_inc), .ld_en(ld_en),
      .ld_val(ld_val), .ptr_inc(ptr_inc), .xaddr(xaddr)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // One clock: inputs were set mid-cycle, results sampled 1 ns after the edge
   task automatic cyc();
      @(posedge clk);
      #1;
      sfr_we = 1'b0; ctl_inc = 1'b0; ld_en = 1'b0; ptr_inc = 1'b0;
   endtask

   task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
      cyc();
   endtask

   task automatic sfr_rd(input logic [7:0] a, output logic [7:0] d);
      sfr_addr = a;
      #1;
      d = sfr_rdata;
   endtask

   task automatic load(input logic [15:0] v);
      ld_val = v; ld_en = 1'b1;
      cyc();
   endtask

   task automatic toggle();
      ctl_inc = 1'b1;
      cyc();
   endtask

   task automatic bump();
      ptr_inc = 1'b1;
      cyc();
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 xaddr", xaddr, 16'h0000);
      sfr_rd(8'hA2, d); check("R1 ctl", {8'h0, d}, 16'h0000);
      sfr_rd(8'h82, d); check("R1 lo", {8'h0, d}, 16'h0000);
      sfr_rd(8'h83, d); check("R1 hi", {8'h0, d}, 16'h0000);
   endtask

   task automatic t_bytes();
      logic [7:0] d;
      sfr_wr(8'h82, 8'h34);
      sfr_wr(8'h83, 8'h12);
      check("R2 xaddr", xaddr, 16'h1234);
      sfr_rd(8'h82, d); check("R2 lo read", {8'h0, d}, 16'h0034);
      sfr_rd(8'h83, d); check("R2 hi read", {8'h0, d}, 16'h0012);
   endtask

   task automatic t_ctl();
      logic [7:0] d;
      sfr_wr(8'hA2, 8'hFF);
      sfr_rd(8'hA2, d); check("R3 ctl masked", {8'h0, d}, 16'h0001);
      check("R3 ptr1 view", xaddr, 16'h0000);
      sfr_wr(8'hA2, 8'hFE);
      sfr_rd(8'hA2, d); check("R3 ctl clear", {8'h0, d}, 16'h0000);
      check("R3 ptr0 view", xaddr, 16'h1234);
   endtask

   task automatic t_toggle();
      logic [7:0] d;
      toggle();
      sfr_rd(8'hA2, d); check("R4 first toggle", {8'h0, d}, 16'h0001);
      toggle();
      sfr_rd(8'hA2, d); check("R4 second toggle", {8'h0, d}, 16'h0000);
   endtask

   task automatic t_load();
      load(16'hBEEF);
      check("R5 ptr0 loaded", xaddr, 16'hBEEF);
      toggle();
      check("R5 ptr1 untouched", xaddr, 16'h0000);
      load(16'h1357);
      toggle();
      check("R5 ptr0 kept", xaddr, 16'hBEEF);
   endtask

   task automatic t_inc();
      load(16'h00FF);
      bump();
      check("R6 carry", xaddr, 16'h0100);
      load(16'hFFFF);
      bump();
      check("R6 wrap", xaddr, 16'h0000);
      bump();
      check("R6 step", xaddr, 16'h0001);
      toggle();
      check("R6 ptr1 unaffected", xaddr, 16'h1357);
      toggle();
   endtask

   task automatic t_prio();
      ld_val = 16'h4242; ld_en = 1'b1; ptr_inc = 1'b1;
      cyc();
      check("R7 load over inc", xaddr, 16'h4242);
      sfr_addr = 8'h82; sfr_wdata = 8'hAA; sfr_we = 1'b1; ptr_inc = 1'b1;
      cyc();
      check("R7 byte write over inc", xaddr, 16'h42AA);
      sfr_addr = 8'h83; sfr_wdata = 8'h99; sfr_we = 1'b1;
      ld_val = 16'h7777; ld_en = 1'b1;
      cyc();
      check("R7 load over byte write", xaddr, 16'h7777);
   endtask

   task automatic t_view();
      ctl_inc = 1'b1;
      @(posedge clk); #1;
      check("R8 view after toggle", xaddr, 16'h1357);
      ctl_inc = 1'b0;
      toggle();
      check("R8 view back", xaddr, 16'h7777);
   endtask

   task automatic t_race();
      logic [7:0] d;
      sfr_addr = 8'hA2; sfr_wdata = 8'h00; sfr_we = 1'b1; ctl_inc = 1'b1;
      cyc();
      sfr_rd(8'hA2, d); check("R9 write 0 wins", {8'h0, d}, 16'h0000);
      sfr_addr = 8'hA2; sfr_wdata = 8'h01; sfr_we = 1'b1; ctl_inc = 1'b1;
      cyc();
      sfr_rd(8'hA2, d); check("R9 write 1 wins", {8'h0, d}, 16'h0001);
      sfr_wr(8'hA2, 8'h00);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      sfr_wr(8'h80, 8'h55);
      sfr_wr(8'h84, 8'h01);
      check("R10 ptr unchanged", xaddr, 16'h7777);
      sfr_rd(8'hA2, d); check("R10 select unchanged", {8'h0, d}, 16'h0000);
      sfr_rd(8'h80, d); check("R10 read 80h", {8'h0, d}, 16'h0000);
      sfr_rd(8'h84, d); check("R10 read 84h", {8'h0, d}, 16'h0000);
   endtask

   initial begin
      rst_n = 1'b0; sfr_addr = '0; sfr_wdata = '0; sfr_we = 1'b0;
      ctl_inc = 1'b0; ld_en = 1'b0; ld_val = '0; ptr_inc = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      t_reset();
      t_bytes();
      t_ctl();
      t_toggle();
      t_load();
      t_inc();
      t_prio();
      t_view();
      t_race();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule